// File: doc/BRIEF.md
# Timed Flash Self-Programming Command Controller

This block holds the command and status register through which software starts flash self-programming work. A write that sets the go bit arms a command. The armed command stays live only for a short window. Within that window, a store strobe from the CPU completes a lock-bit write, a page erase or a page write. Within a shorter window, a load strobe returns the lock byte or the fuse low byte in place of flash data. If no strobe arrives before the window closes, the command bits clear themselves. They also clear as soon as the command completes.

The block keeps the programmable boot lock bits. These bits are active-low and only ever move from 1 to 0. The block also tracks a read-while-write busy flag around page operations. An EEPROM write in progress locks out every command and every lock or fuse read. The flash array and the CPU sit outside the block. They reach it through the strobes, the pointer, the data byte and the flash read data.

Top module: `fsp_cmd_ctrl`

## Requirements
- R1: After reset, `csr_rdata` is 0x00, `rww_busy` and every request pulse are 0, the lock byte equals `LOCK_RST` (0xFF), and `ld_data` follows `flash_rdata`.
- R2: Command register bits: bit0 go, bit1 page erase, bit2 page write, bit3 lock select, bit4 busy re-enable, bit6 busy flag (read-only). A write with bit0 set shows bits 3..0 on `csr_rdata` while armed. Writing 0x09 arms a lock command.
- R3: An armed lock command followed by `st_strobe` 1 to 4 cycles after the write cycle programs the lock bits. It also raises `lock_wr_req` for the cycle after the strobe.
- R4: With no strobe, the command bits read back for 4 cycles after the write and read 0x0 from the 5th cycle on. A store strobe in the 5th cycle has no effect.
- R5: With a lock command armed, a load 1 to 3 cycles after the write returns the data selected by `zptr`. Pointer 0x0001 returns the lock byte and pointer 0x0000 returns `fuse_lo`. From the 4th cycle on, `flash_rdata` is returned.
- R6: A completed store or load clears bits 3..0 at the next edge. At most one request pulse is high at a time.
- R7: In a lock write, each of data bits 5..2 that is 0 clears the matching lock bit. A 1 leaves the bit unchanged, and no write ever sets a lock bit back to 1.
- R8: Lock byte layout: boot lock bits in 5..2, in the order bit5, bit4, bit3, bit2. Bits 7, 6, 1 and 0 keep their reset value whatever data is written.
- R9: A store that completes an erase command (0x03) or a write command (0x05) pulses `pg_erase_req` or `pg_write_req` and sets `rww_busy` (`csr_rdata` bit6). The flag stays set until a register write with bit4 set while `nvm_busy` is 0.
- R10: While `ee_busy` is 1, register writes have no effect, store strobes are ignored, and loads return `flash_rdata`.
- R11: Rewriting the register while a command is armed restarts the window from the new write.
- R12: With no command armed, a load returns `flash_rdata` at any pointer. It also does so while a lock command is armed, at a pointer other than 0x0000 or 0x0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | Command register write strobe |
| csr_wdata | input | 8 | Command register write data |
| csr_rdata | output | 8 | Command register readback |
| st_strobe | input | 1 | CPU program-store strobe |
| ld_strobe | input | 1 | CPU program-load strobe |
| zptr | input | PTR_W | Pointer address |
| r0_data | input | 8 | Data byte for lock programming |
| ee_busy | input | 1 | EEPROM write in progress |
| nvm_busy | input | 1 | Flash page operation in progress |
| fuse_lo | input | 8 | Fuse low byte value |
| flash_rdata | input | 8 | Normal flash read data |
| ld_data | output | 8 | Load result (lock, fuse or flash data) |
| lock_wr_req | output | 1 | Lock-bit write request pulse |
| pg_erase_req | output | 1 | Page erase request pulse |
| pg_write_req | output | 1 | Page write request pulse |
| rww_busy | output | 1 | Read-while-write section busy |

## Verification
The bench steps strobes across both window edges. It places stores at cycles 4 and 5 and loads at cycles 3 and 4, so a window that is off by one either takes a late strobe or drops a valid one. It rewrites the register inside an open window and then strikes late: a design that extends or ignores the reload misses the store or takes it at the wrong time. It writes lock data that holds ones and zeros outside bits 5..2, so a design that sets bits back to 1 or writes the fixed bits shows a wrong lock byte. It also holds the busy flag and the EEPROM interlock through writes that must not clear or arm anything.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

   localparam int unsigned B_GO      = 0;
   localparam int unsigned B_ERASE   = 1;
   localparam int unsigned B_WRITE   = 2;
   localparam int unsigned B_LOCK    = 3;
   localparam int unsigned B_RWWEN   = 4;
   localparam int unsigned B_RWWBUSY = 6;
   localparam int unsigned CMD_W     = 4;

   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_LOCK  = 2'd1,
      OP_ERASE = 2'd2,
      OP_WRITE = 2'd3
   } fsp_op_e;

   function automatic fsp_op_e decode_op(input logic [CMD_W-1:0] c);
      fsp_op_e r;
      if (!c[B_GO])          r = OP_NONE;
      else if (c[B_LOCK])    r = OP_LOCK;
      else if (c[B_ERASE])   r = OP_ERASE;
      else if (c[B_WRITE])   r = OP_WRITE;
      else                   r = OP_NONE;
      return r;
   endfunction

endpackage

// File: rtl/fsp_window.sv
module fsp_window #(
   parameter int unsigned ST_WIN = 4,
   parameter int unsigned LD_WIN = 3,
   localparam int unsigned WIN_MAX = (ST_WIN > LD_WIN) ? ST_WIN : LD_WIN,
   localparam int unsigned AGE_W   = $clog2(WIN_MAX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm_i,
   input  logic             drop_i,
   output logic             armed_o,
   output logic [AGE_W-1:0] age_o,
   output logic             st_ok_o,
   output logic             ld_ok_o
);

   localparam logic [AGE_W-1:0] ST_LIM  = AGE_W'(ST_WIN);
   localparam logic [AGE_W-1:0] LD_LIM  = AGE_W'(LD_WIN);
   localparam logic [AGE_W-1:0] MAX_LIM = AGE_W'(WIN_MAX);

   logic             armed_q;
   logic [AGE_W-1:0] age_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         age_q   <= '0;
      end else if (arm_i) begin
         armed_q <= 1'b1;
         age_q   <= AGE_W'(1);
      end else if (drop_i) begin
         armed_q <= 1'b0;
         age_q   <= '0;
      end else if (armed_q) begin
         if (age_q == MAX_LIM) begin
            armed_q <= 1'b0;
            age_q   <= '0;
         end else begin
            age_q <= age_q + AGE_W'(1);
         end
      end
   end

   assign armed_o = armed_q;
   assign age_o   = age_q;
   assign st_ok_o = armed_q && (age_q <= ST_LIM);
   assign ld_ok_o = armed_q && (age_q <= LD_LIM);

endmodule

// File: rtl/fsp_lock_bank.sv
module fsp_lock_bank #(
   parameter int unsigned   W         = 8,
   parameter logic [W-1:0]  RST_VAL   = '1,
   parameter logic [W-1:0]  PROG_MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         prog_i,
   input  logic [W-1:0] data_i,
   output logic [W-1:0] lock_o
);

   for (genvar gi = 0; gi < W; gi++) begin : g_bit
      if (PROG_MASK[gi]) begin : g_prog
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      bit_q <= RST_VAL[gi];
            else if (prog_i) bit_q <= bit_q & data_i[gi];
         end
         assign lock_o[gi] = bit_q;
      end else begin : g_fixed
         assign lock_o[gi] = RST_VAL[gi];
      end
   end

endmodule

// File: rtl/fsp_rww_track.sv
module fsp_rww_track (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_req_i,
   input  logic op_busy_i,
   output logic busy_o
);

   logic busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       busy_q <= 1'b0;
      else if (set_i)                   busy_q <= 1'b1;
      else if (clr_req_i && !op_busy_i) busy_q <= 1'b0;
   end

   assign busy_o = busy_q;

endmodule

// File: rtl/fsp_cmd_ctrl.sv
module fsp_cmd_ctrl
   import fsp_pkg::*;
#(
   parameter int unsigned  PTR_W     = 16,
   parameter int unsigned  ST_WIN    = 4,
   parameter int unsigned  LD_WIN    = 3,
   parameter logic [7:0]   LOCK_RST  = 8'hFF,
   parameter logic [7:0]   PROG_MASK = 8'h3C,
   parameter logic [15:0]  LOCK_ADDR = 16'h0001,
   parameter logic [15:0]  FUSE_ADDR = 16'h0000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             csr_we,
   input  logic [7:0]       csr_wdata,
   output logic [7:0]       csr_rdata,
   input  logic             st_strobe,
   input  logic             ld_strobe,
   input  logic [PTR_W-1:0] zptr,
   input  logic [7:0]       r0_data,
   input  logic             ee_busy,
   input  logic             nvm_busy,
   input  logic [7:0]       fuse_lo,
   input  logic [7:0]       flash_rdata,
   output logic [7:0]       ld_data,
   output logic             lock_wr_req,
   output logic             pg_erase_req,
   output logic             pg_write_req,
   output logic             rww_busy
);

   localparam int unsigned WIN_MAX = (ST_WIN > LD_WIN) ? ST_WIN : LD_WIN;
   localparam int unsigned AGE_W   = $clog2(WIN_MAX + 1);
   localparam logic [PTR_W-1:0] LOCK_PTR = PTR_W'(LOCK_ADDR);
   localparam logic [PTR_W-1:0] FUSE_PTR = PTR_W'(FUSE_ADDR);

   if (ST_WIN < 1 || LD_WIN < 1) begin : g_bad_win
      $error("fsp_cmd_ctrl: both windows must be at least one cycle");
   end
   if (PTR_W < 1 || PTR_W > 16) begin : g_bad_ptr
      $error("fsp_cmd_ctrl: PTR_W must be 1 to 16");
   end
   if (LOCK_PTR == FUSE_PTR) begin : g_bad_addr
      $error("fsp_cmd_ctrl: lock and fuse pointers must differ");
   end

   logic             csr_take;
   logic             arm;
   logic             drop;
   logic             armed;
   logic [AGE_W-1:0] win_age;
   logic             st_ok;
   logic             ld_ok;
   logic [CMD_W-1:0] cmd_q;
   logic [CMD_W-1:0] cmd_vis;
   fsp_op_e          op;
   logic             st_fire;
   logic             ld_fire;
   logic             rd_sel;
   logic             lock_prog;
   logic             page_fire;
   logic             rww_clr;
   logic [7:0]       lock_q;
   logic             unused_wbits;

   assign unused_wbits = ^{csr_wdata[7:5]};

   assign csr_take = csr_we && !ee_busy;
   assign arm      = csr_take && csr_wdata[B_GO];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cmd_q <= '0;
      else if (csr_take) cmd_q <= csr_wdata[B_GO] ? csr_wdata[CMD_W-1:0] : '0;
   end

   assign cmd_vis = armed ? cmd_q : '0;
   assign op      = decode_op(cmd_vis);

   assign st_fire = st_strobe && st_ok && !ee_busy && !csr_we;
   assign rd_sel  = (op == OP_LOCK) && ld_ok && !ee_busy;
   assign ld_fire = ld_strobe && rd_sel && (zptr == LOCK_PTR || zptr == FUSE_PTR);
   assign drop    = (csr_take && !csr_wdata[B_GO]) || st_fire || ld_fire;

   fsp_window #(
      .ST_WIN (ST_WIN),
      .LD_WIN (LD_WIN)
   ) u_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm_i   (arm),
      .drop_i  (drop),
      .armed_o (armed),
      .age_o   (win_age),
      .st_ok_o (st_ok),
      .ld_ok_o (ld_ok)
   );

   assign lock_prog = st_fire && (op == OP_LOCK);
   assign page_fire = st_fire && (op == OP_ERASE || op == OP_WRITE);

   fsp_lock_bank #(
      .W         (8),
      .RST_VAL   (LOCK_RST),
      .PROG_MASK (PROG_MASK)
   ) u_lock (
      .clk    (clk),
      .rst_n  (rst_n),
      .prog_i (lock_prog),
      .data_i (r0_data),
      .lock_o (lock_q)
   );

   assign rww_clr = csr_take && csr_wdata[B_RWWEN];

   fsp_rww_track u_rww (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (page_fire),
      .clr_req_i (rww_clr),
      .op_busy_i (nvm_busy),
      .busy_o    (rww_busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_wr_req  <= 1'b0;
         pg_erase_req <= 1'b0;
         pg_write_req <= 1'b0;
      end else begin
         lock_wr_req  <= lock_prog;
         pg_erase_req <= st_fire && (op == OP_ERASE);
         pg_write_req <= st_fire && (op == OP_WRITE);
      end
   end

   always_comb begin
      if (rd_sel && zptr == LOCK_PTR)      ld_data = lock_q;
      else if (rd_sel && zptr == FUSE_PTR) ld_data = fuse_lo;
      else                                 ld_data = flash_rdata;
   end

   always_comb begin
      csr_rdata              = '0;
      csr_rdata[CMD_W-1:0]   = cmd_vis;
      csr_rdata[B_RWWBUSY]   = rww_busy;
   end

endmodule

// File: rtl/fsp_cmd_ctrl_chk.sv
module fsp_cmd_ctrl_chk #(
   parameter int unsigned ST_WIN = 4,
   parameter int unsigned LD_WIN = 3,
   localparam int unsigned WIN_MAX = (ST_WIN > LD_WIN) ? ST_WIN : LD_WIN,
   localparam int unsigned AGE_W   = $clog2(WIN_MAX + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             csr_we,
   input logic             st_strobe,
   input logic             ee_busy,
   input logic             nvm_busy,
   input logic [7:0]       lock_q,
   input logic             lock_wr_req,
   input logic             pg_erase_req,
   input logic             pg_write_req,
   input logic             rww_busy,
   input logic             armed,
   input logic [AGE_W-1:0] win_age
);

   localparam logic [AGE_W-1:0] MAX_LIM = AGE_W'(WIN_MAX);

   AST_LOCK_NO_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((lock_q & ~$past(lock_q)) == 8'h00)); // R7

   AST_LOCK_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      lock_wr_req |-> $past(st_strobe)); // R3

   AST_AGE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (win_age != '0 && win_age <= MAX_LIM)); // R4

   AST_WINDOW_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && win_age == MAX_LIM && !csr_we) |=> !armed); // R4

   AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({lock_wr_req, pg_erase_req, pg_write_req})); // R6

   AST_RWW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (rww_busy && nvm_busy) |=> rww_busy); // R9

   AST_EE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      ee_busy |=> !(lock_wr_req || pg_erase_req || pg_write_req)); // R10

endmodule

bind fsp_cmd_ctrl fsp_cmd_ctrl_chk #(
   .ST_WIN (ST_WIN),
   .LD_WIN (LD_WIN)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .csr_we       (csr_we),
   .st_strobe    (st_strobe),
   .ee_busy      (ee_busy),
   .nvm_busy     (nvm_busy),
   .lock_q       (lock_q),
   .lock_wr_req  (lock_wr_req),
   .pg_erase_req (pg_erase_req),
   .pg_write_req (pg_write_req),
   .rww_busy     (rww_busy),
   .armed        (armed),
   .win_age      (win_age)
);

// File: tb/tb_fsp_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_fsp_cmd_ctrl;

   localparam logic [7:0] FLASH = 8'h5A;
   localparam logic [7:0] FUSE  = 8'h62;
   localparam logic [7:0] KEEP  = 8'hC3;
   localparam int NVEC = 9;
   // [15:12] cycle offset after the write, [8] 1 = load, [7:0] r0 data or pointer
   localparam logic [15:0] VEC [NVEC] = '{
      16'h1_0FF, 16'h4_0FB, 16'h5_0C3, 16'h3_101, 16'h4_101,
      16'h2_100, 16'h2_0EF, 16'h3_0F6, 16'h1_102
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_we = 1'b0;
   logic [7:0]  csr_wdata = '0;
   logic [7:0]  csr_rdata;
   logic        st_strobe = 1'b0;
   logic        ld_strobe = 1'b0;
   logic [15:0] zptr = '0;
   logic [7:0]  r0_data = '0;
   logic        ee_busy = 1'b0;
   logic        nvm_busy = 1'b0;
   logic [7:0]  ld_data;
   logic        lock_wr_req, pg_erase_req, pg_write_req, rww_busy;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;
   logic [7:0] model_lock = 8'hFF;

   always #2 clk = ~clk;

   fsp_cmd_ctrl dut (
      .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
      .csr_rdata(csr_rdata), .st_strobe(st_strobe), .ld_strobe(ld_strobe),
      .zptr(zptr), .r0_data(r0_data), .ee_busy(ee_busy), .nvm_busy(nvm_busy),
      .fuse_lo(FUSE), .flash_rdata(FLASH), .ld_data(ld_data),
      .lock_wr_req(lock_wr_req), .pg_erase_req(pg_erase_req),
      .pg_write_req(pg_write_req), .rww_busy(rww_busy)
   );

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic csr_write(input logic [7:0] v);
      csr_we = 1'b1;
      csr_wdata = v;
      tick();
      csr_we = 1'b0;
      csr_wdata = '0;
   endtask

   task automatic read_lock(input string req);
      csr_write(8'h09);
      zptr = 16'h0001;
      ld_strobe = 1'b1;
      #1 chk(ld_data, model_lock, req);
      tick();
      ld_strobe = 1'b0;
      chk({4'h0, csr_rdata[3:0]}, 8'h00, "R6 bits clear after read");
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk(csr_rdata, 8'h00, "R1 csr");
      chk({7'b0, rww_busy}, 8'h00, "R1 rww");
      chk({5'b0, lock_wr_req, pg_erase_req, pg_write_req}, 8'h00, "R1 pulses");
      chk(ld_data, FLASH, "R1 ld_data");
      rst_n = 1'b1;
      tick();
      read_lock("R1 lock reset value");

      // R12 passthrough when nothing armed
      zptr = 16'h0001; ld_strobe = 1'b1;
      #1 chk(ld_data, FLASH, "R12 unarmed load");
      tick(); ld_strobe = 1'b0;

      // R2 arming readback
      csr_write(8'h09);
      chk(csr_rdata, 8'h09, "R2 armed readback");
      repeat (6) tick();

      // vector table: window edges for store and load
      for (int i = 0; i < NVEC; i++) begin
         int k;
         logic is_ld;
         logic [7:0] val;
         k = int'(VEC[i][15:12]);
         is_ld = VEC[i][8];
         val = VEC[i][7:0];
         csr_write(8'h09);
         repeat (k - 1) tick();
         if (is_ld) begin
            logic [7:0] exp;
            zptr = {8'h00, val};
            ld_strobe = 1'b1;
            if (k <= 3 && val == 8'h01)      exp = model_lock;
            else if (k <= 3 && val == 8'h00) exp = FUSE;
            else                             exp = FLASH;
            #1 chk(ld_data, exp, (val > 8'h01) ? "R12 other pointer" : "R5 load window");
            tick();
            ld_strobe = 1'b0;
         end else begin
            r0_data = val;
            st_strobe = 1'b1;
            tick();
            st_strobe = 1'b0;
            chk({7'b0, lock_wr_req}, {7'b0, (k <= 4)}, (k <= 4) ? "R3 store in window" : "R4 late store");
            if (k <= 4) begin
               model_lock = model_lock & (val | KEEP);
               chk({4'h0, csr_rdata[3:0]}, 8'h00, "R6 bits clear after store");
            end
         end
         repeat (6) tick();
         read_lock("R7 R8 lock byte");
      end

      // R4 expiry timing
      csr_write(8'h09);
      repeat (3) tick();
      chk({4'h0, csr_rdata[3:0]}, 8'h09, "R4 still armed cycle 4");
      tick();
      chk({4'h0, csr_rdata[3:0]}, 8'h00, "R4 cleared cycle 5");

      // R11 rewrite reloads the window
      csr_write(8'h09);
      repeat (2) tick();
      csr_write(8'h09);
      repeat (3) tick();
      chk({4'h0, csr_rdata[3:0]}, 8'h09, "R11 armed after reload");
      r0_data = 8'hDF; st_strobe = 1'b1;
      tick(); st_strobe = 1'b0;
      chk({7'b0, lock_wr_req}, 8'h01, "R11 store after reload");
      model_lock = model_lock & (8'hDF | KEEP);
      repeat (6) tick();
      read_lock("R11 lock after reload");

      // R9 page erase and busy flag
      csr_write(8'h03);
      st_strobe = 1'b1; tick(); st_strobe = 1'b0;
      chk({7'b0, pg_erase_req}, 8'h01, "R9 erase pulse");
      chk(csr_rdata, 8'h40, "R9 busy bit after erase");
      nvm_busy = 1'b1;
      tick();
      csr_write(8'h10);
      chk({7'b0, rww_busy}, 8'h01, "R9 busy held while op runs");
      nvm_busy = 1'b0;
      repeat (3) tick();
      chk({7'b0, rww_busy}, 8'h01, "R9 busy held without re-enable");
      csr_write(8'h10);
      chk({7'b0, rww_busy}, 8'h00, "R9 busy cleared by re-enable");
      csr_write(8'h05);
      st_strobe = 1'b1; tick(); st_strobe = 1'b0;
      chk({7'b0, pg_write_req}, 8'h01, "R9 write pulse");
      chk({7'b0, rww_busy}, 8'h01, "R9 busy after write");
      csr_write(8'h10);
      chk({7'b0, rww_busy}, 8'h00, "R9 busy cleared again");

      // R10 EEPROM interlock
      ee_busy = 1'b1;
      csr_write(8'h09);
      chk({4'h0, csr_rdata[3:0]}, 8'h00, "R10 write blocked");
      ee_busy = 1'b0;
      csr_write(8'h09);
      ee_busy = 1'b1; r0_data = 8'h00; st_strobe = 1'b1;
      tick(); st_strobe = 1'b0;
      chk({7'b0, lock_wr_req}, 8'h00, "R10 store blocked");
      zptr = 16'h0001; ld_strobe = 1'b1;
      #1 chk(ld_data, FLASH, "R10 read blocked");
      tick(); ld_strobe = 1'b0; ee_busy = 1'b0;
      repeat (6) tick();
      read_lock("R10 lock unchanged");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule